// File: doc/BRIEF.md
# Element Saturating Result Clamp

This block takes one integer element result and limits it to the range of a chosen destination element width. The result is computed upstream at the wider of the source and destination widths. The block clamps it to 8, 16, 32 or 64 bits, either as an unsigned or as a signed quantity. Nothing is ever cut down to the destination width by dropping high bits while saturation is on: only the clamp narrows the value.

Each element also gets its own overflow bit, for that element's own condition field. The bit says only whether clamping happened on this element. A sticky summary-overflow input plays no part in it. Asking for saturation on an operation that also has overflow-enable set is reported as an illegal instruction. Carry bits coming from the operation are forced to zero whenever saturation is on, so they always have a defined value.

The datapath is purely combinational. A parameter chooses whether an output register follows it. With the register (the default) the outputs appear one clock after the input is presented.

Top module: `elem_sat_clamp`

## Requirements
- R1: Unsigned mode (`signed_i`=0, `sat_en_i`=1): a result above 2^w-1 becomes 2^w-1, and a negative result becomes 0, where w is the destination width.
- R2: Signed mode (`signed_i`=1, `sat_en_i`=1): a result above 2^(w-1)-1 becomes 2^(w-1)-1, and a result below -2^(w-1) becomes -2^(w-1). Both are given as a w-bit two's complement pattern.
- R3: A result inside the range, including one exactly at either limit, comes out unchanged as its low w bits, and it does not set the overflow bit.
- R4: The destination width code `dst_width_i` selects the width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Bits of `value_o` at and above position w are always 0.
- R5: `ovf_o` is 1 exactly when `rec_en_i`, `sat_en_i` and a clamp are all present. The input `so_i` never affects it.
- R6: `illegal_o` is 1 exactly when `sat_en_i` and `oe_i` are both 1.
- R7: `carry_o` is 0 when `sat_en_i` is 1. Otherwise it equals `carry_i`.
- R8: With `sat_en_i`=0, `value_o` is the low w bits of the result (wrapping), and `ovf_o` is 0.
- R9: With `REG_OUT`=1, all outputs appear in the cycle after `in_valid` is sampled high, and `out_valid` marks them. Reset clears `out_valid` and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| res_i | input | RES_W | Wide two's complement result |
| dst_width_i | input | 2 | Destination width code (0:8, 1:16, 2:32, 3:64) |
| signed_i | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| sat_en_i | input | 1 | Saturation requested |
| rec_en_i | input | 1 | Record the overflow bit in the condition field |
| oe_i | input | 1 | Overflow-enable of the operation |
| so_i | input | 1 | Sticky summary-overflow state (no effect) |
| carry_i | input | 2 | Carry bits from the operation |
| out_valid | output | 1 | Output element present |
| value_o | output | 64 | Clamped value, zero above bit w-1 |
| ovf_o | output | 1 | Per-element overflow (clamp happened) |
| illegal_o | output | 1 | Saturation combined with overflow-enable |
| carry_o | output | 2 | Carry bits, zero under saturation |

## Verification
The bench aims at the exact limits of every width and sign: 255 and -128 at 8 bits, the all-ones 64-bit pattern, and values one step past each limit. A design with an off-by-one comparison would flag overflow at a limit, or would let the next value through unclamped. Negative inputs in unsigned mode must give 0; a design that compared without sign would saturate them to the maximum instead. Further cases set `so_i` while the result is in range, and clamp with recording off. A design that mixed in the sticky state, or ignored the record enable, would raise `ovf_o` when it should not. Wrapping with saturation off, and the forced carry zero, catch a clamp or a carry mask that is applied in the wrong mode.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;

  localparam int ELEM_MAX_W = 64;
  localparam int CARRY_W    = 2;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_width_e;

  typedef struct packed {
    logic [ELEM_MAX_W-1:0] value;
    logic                  ovf;
    logic                  illegal;
    logic [CARRY_W-1:0]    carry;
  } clamp_out_t;

  function automatic int unsigned width_bits(elem_width_e code);
    return 32'd8 << code;
  endfunction

  function automatic logic [ELEM_MAX_W-1:0] width_mask(elem_width_e code);
    logic [ELEM_MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < ELEM_MAX_W; i++) begin
      m[i] = (i < int'(width_bits(code)));
    end
    return m;
  endfunction

endpackage

// File: rtl/sat_limit_gen.sv
module sat_limit_gen
  import sat_clamp_pkg::*;
#(
  parameter int RES_W = 72
) (
  input  elem_width_e            width_i,
  input  logic                   signed_i,
  output logic [RES_W-1:0]       hi_lim_o,
  output logic [RES_W-1:0]       lo_lim_o,
  output logic [ELEM_MAX_W-1:0]  mask_o
);

  localparam logic [RES_W-1:0] ONE = RES_W'(1);

  int unsigned wb;
  logic [RES_W-1:0] pow_w;
  logic [RES_W-1:0] pow_wm1;

  always_comb begin
    wb      = width_bits(width_i);
    pow_w   = ONE << wb;
    pow_wm1 = ONE << (wb - 32'd1);
    if (signed_i) begin
      hi_lim_o = pow_wm1 - ONE;
      lo_lim_o = '0 - pow_wm1;
    end else begin
      hi_lim_o = pow_w - ONE;
      lo_lim_o = '0;
    end
    mask_o = width_mask(width_i);
  end

endmodule

// File: rtl/sat_select.sv
module sat_select #(
  parameter int RES_W = 72
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [RES_W-1:0] hi_lim_i,
  input  logic [RES_W-1:0] lo_lim_i,
  input  logic             sat_en_i,
  output logic [RES_W-1:0] sel_o,
  output logic             clamped_o
);

  logic above;
  logic below;

  always_comb begin
    above = $signed(res_i) > $signed(hi_lim_i);
    below = $signed(res_i) < $signed(lo_lim_i);
    sel_o = res_i;
    if (sat_en_i && above) begin
      sel_o = hi_lim_i;
    end else if (sat_en_i && below) begin
      sel_o = lo_lim_i;
    end
    clamped_o = sat_en_i && (above || below);
  end

endmodule

// File: rtl/sat_out_stage.sv
module sat_out_stage
  import sat_clamp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  clamp_out_t data_i,
  output logic       valid_o,
  output clamp_out_t data_o
);

  generate
    if (REG_OUT) begin : g_reg
      clamp_out_t data_q;
      clamp_out_t data_d;
      logic       valid_q;
      logic       valid_d;
      logic       data_en;

      always_comb begin
        data_en = valid_i;
        valid_d = valid_i;
        data_d  = data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          data_q  <= '0;
        end else begin
          valid_q <= valid_d;
          if (data_en) begin
            data_q <= data_d;
          end
        end
      end

      assign valid_o = valid_q;
      assign data_o  = data_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign valid_o = valid_i;
      assign data_o  = data_i;
    end
  endgenerate

endmodule

// File: rtl/elem_sat_clamp.sv
module elem_sat_clamp
  import sat_clamp_pkg::*;
#(
  parameter int RES_W   = 72,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [RES_W-1:0]      res_i,
  input  logic [1:0]            dst_width_i,
  input  logic                  signed_i,
  input  logic                  sat_en_i,
  input  logic                  rec_en_i,
  input  logic                  oe_i,
  input  logic                  so_i,
  input  logic [CARRY_W-1:0]    carry_i,
  output logic                  out_valid,
  output logic [ELEM_MAX_W-1:0] value_o,
  output logic                  ovf_o,
  output logic                  illegal_o,
  output logic [CARRY_W-1:0]    carry_o
);

  elem_width_e            width_code;
  logic [RES_W-1:0]       hi_lim;
  logic [RES_W-1:0]       lo_lim;
  logic [ELEM_MAX_W-1:0]  mask;
  logic [RES_W-1:0]       sel;
  logic                   clamped;
  clamp_out_t             comb_out;
  clamp_out_t             stage_out;

  assign width_code = elem_width_e'(dst_width_i);

  sat_limit_gen #(.RES_W(RES_W)) u_limits (
    .width_i  (width_code),
    .signed_i (signed_i),
    .hi_lim_o (hi_lim),
    .lo_lim_o (lo_lim),
    .mask_o   (mask)
  );

  sat_select #(.RES_W(RES_W)) u_select (
    .res_i     (res_i),
    .hi_lim_i  (hi_lim),
    .lo_lim_i  (lo_lim),
    .sat_en_i  (sat_en_i),
    .sel_o     (sel),
    .clamped_o (clamped)
  );

  always_comb begin
    comb_out.value   = sel[ELEM_MAX_W-1:0] & mask;
    comb_out.ovf     = rec_en_i && clamped;
    comb_out.illegal = sat_en_i && oe_i;
    comb_out.carry   = sat_en_i ? '0 : carry_i;
  end

  sat_out_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .data_i  (comb_out),
    .valid_o (out_valid),
    .data_o  (stage_out)
  );

  assign value_o   = stage_out.value;
  assign ovf_o     = stage_out.ovf;
  assign illegal_o = stage_out.illegal;
  assign carry_o   = stage_out.carry;

endmodule

// File: rtl/sat_clamp_chk.sv
module sat_clamp_chk
  import sat_clamp_pkg::*;
#(
  parameter int RES_W = 72,
  parameter bit LAT   = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [RES_W-1:0]      res_i,
  input logic [1:0]            dst_width_i,
  input logic                  sat_en_i,
  input logic                  rec_en_i,
  input logic                  oe_i,
  input logic                  so_i,
  input logic [CARRY_W-1:0]    carry_i,
  input logic                  out_valid,
  input logic [ELEM_MAX_W-1:0] value_o,
  input logic                  ovf_o,
  input logic                  illegal_o,
  input logic [CARRY_W-1:0]    carry_o
);

  logic                  d_valid;
  logic [RES_W-1:0]      d_res;
  logic [1:0]            d_w;
  logic                  d_sat;
  logic                  d_rec;
  logic                  d_oe;
  logic                  d_so;
  logic [CARRY_W-1:0]    d_carry;
  logic [ELEM_MAX_W-1:0] d_mask;

  generate
    if (LAT) begin : g_delay
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_valid <= 1'b0;
          d_res   <= '0;
          d_w     <= '0;
          d_sat   <= 1'b0;
          d_rec   <= 1'b0;
          d_oe    <= 1'b0;
          d_so    <= 1'b0;
          d_carry <= '0;
        end else begin
          d_valid <= in_valid;
          d_res   <= res_i;
          d_w     <= dst_width_i;
          d_sat   <= sat_en_i;
          d_rec   <= rec_en_i;
          d_oe    <= oe_i;
          d_so    <= so_i;
          d_carry <= carry_i;
        end
      end
    end else begin : g_direct
      assign d_valid = in_valid;
      assign d_res   = res_i;
      assign d_w     = dst_width_i;
      assign d_sat   = sat_en_i;
      assign d_rec   = rec_en_i;
      assign d_oe    = oe_i;
      assign d_so    = so_i;
      assign d_carry = carry_i;
    end
  endgenerate

  assign d_mask = width_mask(elem_width_e'(d_w));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == d_valid); // R9

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (illegal_o == (d_sat && d_oe))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(d_sat && d_rec)) |-> !ovf_o); // R5

  AST_SO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && d_so && !d_sat) |-> !ovf_o); // R5

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((value_o & ~d_mask) == '0)); // R4

  AST_CARRY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (carry_o == (d_sat ? '0 : d_carry))); // R7

  AST_WRAP_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !d_sat) |-> (value_o == (d_res[ELEM_MAX_W-1:0] & d_mask))); // R8

endmodule

bind elem_sat_clamp sat_clamp_chk #(.RES_W(RES_W), .LAT(REG_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .res_i       (res_i),
  .dst_width_i (dst_width_i),
  .sat_en_i    (sat_en_i),
  .rec_en_i    (rec_en_i),
  .oe_i        (oe_i),
  .so_i        (so_i),
  .carry_i     (carry_i),
  .out_valid   (out_valid),
  .value_o     (value_o),
  .ovf_o       (ovf_o),
  .illegal_o   (illegal_o),
  .carry_o     (carry_o)
);

// File: tb/tb_elem_sat_clamp.sv
module tb_elem_sat_clamp;

  localparam int RES_W = 72;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [RES_W-1:0]  res_i;
  logic [1:0]        dst_width_i;
  logic              signed_i;
  logic              sat_en_i;
  logic              rec_en_i;
  logic              oe_i;
  logic              so_i;
  logic [1:0]        carry_i;
  logic              out_valid;
  logic [63:0]       value_o;
  logic              ovf_o;
  logic              illegal_o;
  logic [1:0]        carry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] value;
    logic        ovf;
    logic        illegal;
    logic [1:0]  carry;
    string       tag;
  } exp_t;

  exp_t sb[$];

  elem_sat_clamp #(.RES_W(RES_W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_i(res_i),
    .dst_width_i(dst_width_i), .signed_i(signed_i), .sat_en_i(sat_en_i),
    .rec_en_i(rec_en_i), .oe_i(oe_i), .so_i(so_i), .carry_i(carry_i),
    .out_valid(out_valid), .value_o(value_o), .ovf_o(ovf_o),
    .illegal_o(illegal_o), .carry_o(carry_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic signed [RES_W-1:0] r, input int wc,
                                 input bit sg, input bit sat, input bit rec,
                                 input bit oe, input logic [1:0] cy, input string tag);
    exp_t e;
    int wb;
    logic signed [RES_W-1:0] hi;
    logic signed [RES_W-1:0] lo;
    logic signed [RES_W-1:0] v;
    logic [63:0] m;
    bit clip;
    wb = 8 << wc;
    m  = (wb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << wb) - 64'd1);
    if (sg) begin
      hi = (RES_W'(1) <<< (wb - 1)) - 1;
      lo = -(RES_W'(1) <<< (wb - 1));
    end else begin
      hi = (RES_W'(1) <<< wb) - 1;
      lo = '0;
    end
    v = r;
    clip = 1'b0;
    if (sat && r > hi) begin v = hi; clip = 1'b1; end
    if (sat && r < lo) begin v = lo; clip = 1'b1; end
    e.value   = v[63:0] & m;
    e.ovf     = rec && clip;
    e.illegal = sat && oe;
    e.carry   = sat ? 2'b00 : cy;
    e.tag     = tag;
    return e;
  endfunction

  task automatic drive(input logic signed [RES_W-1:0] r, input int wc, input bit sg,
                       input bit sat, input bit rec, input bit oe, input bit so,
                       input logic [1:0] cy, input string tag);
    @(negedge clk);
    in_valid    = 1'b1;
    res_i       = r;
    dst_width_i = 2'(wc);
    signed_i    = sg;
    sat_en_i    = sat;
    rec_en_i    = rec;
    oe_i        = oe;
    so_i        = so;
    carry_i     = cy;
    sb.push_back(model(r, wc, sg, sat, rec, oe, cy, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    res_i    = '1;
  endtask

  // Monitor: results appear one cycle after the driver's negedge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check("R9 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " value"},   value_o,          e.value);
        check({e.tag, " ovf"},     64'(ovf_o),       64'(e.ovf));
        check({e.tag, " illegal"}, 64'(illegal_o),   64'(e.illegal));
        check({e.tag, " carry"},   64'(carry_o),     64'(e.carry));
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; res_i = '1; dst_width_i = 2'd3;
    signed_i = 1'b1; sat_en_i = 1'b1; rec_en_i = 1'b1; oe_i = 1'b1;
    so_i = 1'b1; carry_i = 2'b11;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", 64'(out_valid), 64'd0);
    check("R9 reset value", value_o, 64'd0);
    check("R9 reset ovf", 64'(ovf_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle out_valid", 64'(out_valid), 64'd0);

    drive(72'sd300, 0, 0, 1, 1, 0, 0, 2'b00, "R1 u8 above");
    drive(-72'sd5,  0, 0, 1, 1, 0, 0, 2'b00, "R1 u8 negative");
    drive(72'sd255, 0, 0, 1, 1, 0, 0, 2'b00, "R3 u8 at max");
    drive(72'sd0,   0, 0, 1, 1, 0, 0, 2'b00, "R3 u8 at zero");
    drive(72'sd200, 0, 1, 1, 1, 0, 0, 2'b00, "R2 s8 above");
    drive(-72'sd129,0, 1, 1, 1, 0, 0, 2'b00, "R2 s8 below");
    drive(-72'sd128,0, 1, 1, 1, 0, 0, 2'b00, "R3 s8 at min");
    drive(72'sd127, 0, 1, 1, 1, 0, 0, 2'b00, "R3 s8 at max");
    idle();
    check("R9 gap out_valid", 64'(out_valid), 64'd1);
    idle();
    check("R9 gap idle", 64'(out_valid), 64'd0);
    drive(72'sd70000,  1, 0, 1, 1, 0, 0, 2'b00, "R4 u16 above");
    drive(-72'sd40000, 1, 1, 1, 1, 0, 0, 2'b00, "R4 s16 below");
    drive(72'sh1_0000_0000, 2, 0, 1, 1, 0, 0, 2'b00, "R4 u32 above");
    drive(-72'sd1, 2, 1, 1, 1, 0, 0, 2'b00, "R3 s32 minus one");
    drive(72'sh1_0000_0000_0000_0000, 3, 0, 1, 1, 0, 0, 2'b00, "R1 u64 above");
    drive(72'sh0_8000_0000_0000_0000, 3, 1, 1, 1, 0, 0, 2'b00, "R2 s64 above");
    drive(72'sh0_FFFF_FFFF_FFFF_FFFF, 3, 0, 1, 1, 0, 0, 2'b00, "R3 u64 at max");
    drive(-72'sd1, 3, 0, 1, 1, 0, 0, 2'b00, "R1 u64 negative");
    drive(72'sd300, 0, 0, 1, 0, 0, 0, 2'b00, "R5 clamp rec off");
    drive(72'sd10,  0, 0, 1, 1, 0, 1, 2'b00, "R5 so set in range");
    drive(72'sd300, 0, 0, 1, 1, 0, 1, 2'b00, "R5 so set clamp");
    drive(72'sd10,  1, 1, 1, 0, 1, 0, 2'b00, "R6 sat with oe");
    drive(72'sd10,  1, 1, 0, 0, 1, 0, 2'b00, "R6 oe without sat");
    drive(72'sd10,  1, 0, 1, 0, 0, 0, 2'b11, "R7 carry under sat");
    drive(72'sd10,  1, 0, 0, 0, 0, 0, 2'b10, "R7 carry passes");
    drive(72'sd300, 0, 0, 0, 1, 0, 0, 2'b00, "R8 u8 wrap");
    drive(-72'sd40000, 1, 1, 0, 1, 0, 1, 2'b01, "R8 s16 wrap");
    idle();
    repeat (3) @(negedge clk);
    check("R9 queue drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule